// File: doc/BRIEF.md
# Posted-Write External Bus Sequencer

This block connects one requester, such as a processor load/store port or a DMA engine, to a single external parallel memory bus. The requester uses a valid/ready handshake. Each request carries an address, write data, a write flag and a space index. The block turns each accepted request into a bus cycle. A bus cycle has an active-low strobe for the selected space, a read/write line, an address bus, and a split data bus (output data plus an output enable, and an input data path). The block also samples a ready input from the memory so that slow devices can stretch the cycle.

Writes are posted. On acceptance, the address and data are latched into a single-entry buffer. The requester's handshake completes in that same cycle, so the requester can carry on with internal work. The write then runs on the bus for its nominal two cycles. Any further request, read or write, is held off by a low `req_ready` until that write has finished.

A read runs in one cycle when the bus was idle or was doing another read. If the read is accepted in the very cycle after a write left the bus, a turnaround cycle is inserted first. During the turnaround no strobe is asserted and the data bus is released, so the read occupies two cycles. Read data returns on `rsp_rdata` with a one-cycle `rsp_valid` pulse.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, all strobes are high, `bus_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: While the block is idle, `req_ready` is 1, so a write completes its handshake in the cycle it is presented. The latched address and data appear on the bus in the next cycle.
- R3: With `bus_rdy` high, a write holds its strobe low for exactly two cycles with `bus_rnw` = 0. Address and output data stay constant throughout, and all strobes return high in the third cycle.
- R4: A read that does not directly follow a write holds its strobe low for one cycle with `bus_rnw` = 1. In the next cycle, `rsp_valid` is high for exactly one cycle and `rsp_rdata` equals the value `bus_din` had at the end of the strobe cycle.
- R5: A read accepted in the first idle cycle after a write first spends one turnaround cycle with all strobes high and `bus_oe` = 0. It then spends one strobe cycle, for two cycles in total.
- R6: While a posted write occupies the bus, `req_ready` is 0. A second request presented then is held and starts only after the write ends.
- R7: At most one strobe bit is low at any time. Bit i of `bus_stb_n` is the one used when the accepted request carried space index i.
- R8: `bus_rdy` is sampled only at the end of the nominal cycle count (cycle 2 of a write, cycle 1 of a read). Each low sample adds one cycle, during which strobe, address and output data are held.
- R9: `bus_oe` is 1 only during write strobe cycles, and 0 during reads, the turnaround and idle.
- R10: A read accepted after at least one idle cycle following a write gets no turnaround. Its strobe is low in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | SW | Address-space index selecting the strobe |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DW | Read data |
| bus_stb_n | output | NSPACE | Active-low strobe per address space |
| bus_rnw | output | 1 | 1 = read or idle, 0 = write cycle |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External data driven out |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | DW | External data read in |
| bus_rdy | input | 1 | Memory ready, sampled at the end of the nominal count |

## Verification
The assertions rely on `bus_rdy` settling before each rising edge. They also rely on the requester holding its fields stable while `req_valid` is high and `req_ready` is low. The hold and strobe checks are meaningful only if `bus_din` is a settled function of the address during the strobe. The stimulus drives every input only on falling edges, keeps the request fields constant until the handshake completes, and models the memory as a combinational function of `bus_addr`. `bus_rdy` is low only during the cycles chosen to add wait states.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } pwb_state_e;

  // Nominal bus occupancy of one access before any wait states.
  function automatic int nominal_cycles(input logic is_wr, input int wr_c, input int rd_c);
    return is_wr ? wr_c : rd_c;
  endfunction

  // Width needed to count up to the longer of the two nominal lengths.
  function automatic int count_width(input int wr_c, input int rd_c);
    int m;
    m = (wr_c > rd_c) ? wr_c : rd_c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/pwb_post_buf.sv
module pwb_post_buf #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int SW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_write,
  input  logic [SW-1:0] in_space,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  output logic          q_write,
  output logic [SW-1:0] q_space,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_space <= '0;
      q_addr  <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_write <= in_write;
      q_space <= in_space;
      q_addr  <= in_addr;
      q_wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          last
);

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= '0;
    else if (run && !last) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwb_space_decode.sv
module pwb_space_decode #(
  parameter int NSPACE = 2,
  parameter int SW     = 1
) (
  input  logic              active,
  input  logic [SW-1:0]     space,
  output logic [NSPACE-1:0] stb_n
);

  for (genvar i = 0; i < NSPACE; i++) begin : g_stb
    assign stb_n[i] = !(active && (space == SW'(i)));
  end

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NSPACE = 2,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 1,
  localparam int SW    = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SW-1:0]     req_space,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NSPACE-1:0] bus_stb_n,
  output logic              bus_rnw,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_oe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);

  localparam int CW = count_width(WR_CYC, RD_CYC);

  pwb_state_e    state, state_nx;
  logic          buf_write;
  logic [SW-1:0] buf_space;
  logic [CW-1:0] lim;
  logic          last_wr;

  // Named internal events, used by the FSM and by the bound checker.
  logic acc_fire;     // handshake completes this cycle
  logic turn_needed;  // accepted read directly after a write
  logic bus_active;   // a strobe is asserted this cycle
  logic in_turn;      // turnaround cycle
  logic cyc_last;     // final nominal cycle of the current access
  logic cyc_end;      // access completes at the coming edge
  logic wr_end;
  logic rd_end;
  logic tmr_start;

  assign req_ready   = (state == ST_IDLE);
  assign acc_fire    = req_valid && req_ready;
  assign turn_needed = acc_fire && !req_write && last_wr;
  assign bus_active  = (state == ST_READ) || (state == ST_WRITE);
  assign in_turn     = (state == ST_TURN);
  assign cyc_end     = cyc_last && bus_rdy;
  assign wr_end      = cyc_end && (state == ST_WRITE);
  assign rd_end      = cyc_end && (state == ST_READ);
  assign tmr_start   = (acc_fire && !turn_needed) || in_turn;
  assign lim         = CW'(nominal_cycles(buf_write, WR_CYC, RD_CYC));

  pwb_post_buf #(.AW(AW), .DW(DW), .SW(SW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_fire),
    .in_write (req_write),
    .in_space (req_space),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .q_write  (buf_write),
    .q_space  (buf_space),
    .q_addr   (bus_addr),
    .q_wdata  (bus_dout)
  );

  logic tmr_last;
  pwb_cycle_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .run   (bus_active),
    .limit (lim),
    .last  (tmr_last)
  );
  assign cyc_last = tmr_last && bus_active;

  pwb_space_decode #(.NSPACE(NSPACE), .SW(SW)) u_dec (
    .active (bus_active),
    .space  (buf_space),
    .stb_n  (bus_stb_n)
  );

  assign bus_oe  = (state == ST_WRITE);
  assign bus_rnw = (state != ST_WRITE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (acc_fire) begin
        if (req_write)        state_nx = ST_WRITE;
        else if (turn_needed) state_nx = ST_TURN;
        else                  state_nx = ST_READ;
      end
      ST_TURN:  state_nx = ST_READ;
      ST_READ:  if (cyc_end) state_nx = ST_IDLE;
      ST_WRITE: if (cyc_end) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      last_wr   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= state_nx;
      last_wr   <= wr_end;
      rsp_valid <= rd_end;
      if (rd_end) rsp_rdata <= bus_din;
    end
  end

endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NSPACE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NSPACE-1:0] bus_stb_n,
  input logic              bus_rnw,
  input logic              bus_oe,
  input logic              bus_rdy,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_dout,
  input logic              cyc_last,
  input logic              in_turn
);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_stb_n) <= 1);

  a_r9_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_rnw && !(&bus_stb_n)));

  a_r6_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&bus_stb_n) && !bus_rnw) |-> !req_ready);

  a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_last && !bus_rdy) |=> ($stable(bus_stb_n) && $stable(bus_addr) &&
                                $stable(bus_dout) && $stable(bus_rnw)));

  a_r5_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |-> (&bus_stb_n && !bus_oe));

  a_r5_turn_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |=> (bus_rnw && !(&bus_stb_n)));

  a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r4_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(bus_rnw && !(&bus_stb_n) && bus_rdy));

endmodule

bind pwb_ctrl pwb_ctrl_chk #(.AW(AW), .DW(DW), .NSPACE(NSPACE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_stb_n (bus_stb_n),
  .bus_rnw   (bus_rnw),
  .bus_oe    (bus_oe),
  .bus_rdy   (bus_rdy),
  .bus_addr  (bus_addr),
  .bus_dout  (bus_dout),
  .cyc_last  (cyc_last),
  .in_turn   (in_turn)
);

// File: tb/pwb_ctrl_tb.sv
`timescale 1ns/1ps
module pwb_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [0:0]    req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NS-1:0] bus_stb_n;
  logic          bus_rnw;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic          bus_oe;
  logic [DW-1:0] bus_din;
  logic          bus_rdy = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Memory model: data is a fixed function of the address.
  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {~a, a};
  endfunction
  assign bus_din = mem_val(bus_addr);

  function automatic logic [NS-1:0] stb_for(input int sp);
    return ~(NS'(1) << sp);
  endfunction

  pwb_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_stb_n(bus_stb_n), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(bus_stb_n == '1, "R1 strobes", 64'(bus_stb_n), 64'(3));
    chk(bus_oe == 1'b0, "R1 oe", 64'(bus_oe), 0);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
  endtask

  // Ends on the first idle cycle after the write.
  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int sp, input int nwait);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    req_space = 1'(sp);
    chk(req_ready == 1'b1, "R2 ready when idle", 64'(req_ready), 1);
    cyc();
    req_valid = 1'b0;
    for (int i = 0; i < 2 + nwait; i++) begin
      bus_rdy = !(i >= 1 && i <= nwait);
      chk(bus_stb_n == stb_for(sp), "R3/R7/R8 write strobe",
          64'(bus_stb_n), 64'(stb_for(sp)));
      chk(bus_rnw == 1'b0, "R3 rnw", 64'(bus_rnw), 0);
      chk(bus_oe == 1'b1, "R9 oe on write", 64'(bus_oe), 1);
      chk(bus_addr == a, "R2 addr", 64'(bus_addr), 64'(a));
      chk(bus_dout == d, "R2 data", 64'(bus_dout), 64'(d));
      chk(req_ready == 1'b0, "R6 stalled", 64'(req_ready), 0);
      cyc();
    end
    bus_rdy = 1'b1;
    chk(bus_stb_n == '1, "R3 strobe released", 64'(bus_stb_n), 64'(3));
    chk(bus_oe == 1'b0, "R9 oe off", 64'(bus_oe), 0);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input int sp, input int nwait,
                        input bit turn);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_space = 1'(sp);
    cyc();
    req_valid = 1'b0;
    if (turn) begin
      chk(bus_stb_n == '1, "R5 turn no strobe", 64'(bus_stb_n), 64'(3));
      chk(bus_oe == 1'b0, "R5 turn oe", 64'(bus_oe), 0);
      cyc();
    end
    for (int i = 0; i <= nwait; i++) begin
      bus_rdy = (i >= nwait);
      chk(bus_stb_n == stb_for(sp), turn ? "R5 read strobe" : "R4/R10 read strobe",
          64'(bus_stb_n), 64'(stb_for(sp)));
      chk(bus_rnw == 1'b1, "R4 rnw", 64'(bus_rnw), 1);
      chk(bus_oe == 1'b0, "R9 oe off on read", 64'(bus_oe), 0);
      chk(rsp_valid == 1'b0, "R8 no early rsp", 64'(rsp_valid), 0);
      cyc();
    end
    bus_rdy = 1'b1;
    chk(rsp_valid == 1'b1, "R4 rsp_valid", 64'(rsp_valid), 1);
    chk(rsp_rdata == mem_val(a), "R4 rdata", 64'(rsp_rdata), 64'(mem_val(a)));
    chk(bus_stb_n == '1, "R4 strobe released", 64'(bus_stb_n), 64'(3));
    cyc();
    chk(rsp_valid == 1'b0, "R4 single pulse", 64'(rsp_valid), 0);
  endtask

  task automatic t_stall();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1111;
    req_wdata = 32'hAAAA_0001; req_space = 1'b0;
    cyc();
    req_addr = 16'h2222; req_wdata = 32'hBBBB_0002; req_space = 1'b1;
    for (int i = 0; i < 2; i++) begin
      chk(req_ready == 1'b0, "R6 second held", 64'(req_ready), 0);
      chk(bus_addr == 16'h1111, "R6 first addr kept", 64'(bus_addr), 64'h1111);
      cyc();
    end
    chk(req_ready == 1'b1, "R6 released", 64'(req_ready), 1);
    cyc();
    req_valid = 1'b0;
    chk(bus_addr == 16'h2222, "R6 second addr", 64'(bus_addr), 64'h2222);
    chk(bus_stb_n == stb_for(1), "R7 space 1", 64'(bus_stb_n), 64'(stb_for(1)));
    repeat (2) cyc();
    chk(bus_stb_n == '1, "R6 second done", 64'(bus_stb_n), 64'(3));
  endtask

  initial begin
    t_reset();
    t_write(16'h0010, 32'hDEAD_BEEF, 0, 0);
    cyc();
    t_read(16'h0020, 0, 0, 1'b0);          // R10 idle gap, no turn
    t_write(16'h0030, 32'h1234_5678, 1, 0);
    t_read(16'h0040, 1, 0, 1'b1);          // R5 directly after write
    t_write(16'h0050, 32'h0BAD_F00D, 0, 2); // R8 two waits on write
    cyc();
    t_read(16'h0060, 1, 3, 1'b0);          // R8 three waits on read
    t_stall();
    t_write(16'h0070, 32'hCAFE_0000, 1, 1);
    t_read(16'h0080, 0, 1, 1'b1);          // R5 with a wait state
    repeat (2) cyc();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule